// File: doc/BRIEF.md
# Rank-Aware Read/Write Burst Selector

This block sits between the read and write request queues of a memory controller and decides, every cycle, which queued burst goes to the memory bus next. Each queue presents up to `DEPTH` entries in age order (slot 0 is the oldest, occupied slots are contiguous from slot 0). Every entry carries a valid flag, a ready flag computed elsewhere from per-bank timing, and the rank it targets. The selector keeps the bus direction (read or write) as internal state, offers a grant for one entry of the queue that matches that direction, and holds the grant back until the bus has been quiet long enough.

Two kinds of quiet time are enforced. A burst that targets a rank other than the previous burst's rank needs `T_CS` empty cycles. A burst whose direction differs from the previous burst needs `T_RTW` empty cycles after a read or `T_WTR` empty cycles after a write, and a rank change on top of that adds `T_CS`. To avoid the rank bubble, the selector prefers an entry that targets the previous burst's rank when it continues in the same direction. The direction itself follows two thresholds on write-queue occupancy, so that the bus does not flip back and forth around a single level. Two run counters report how many reads and writes have been issued since the latest change of direction.

A grant is taken by the surrounding queue logic in the cycle it is shown: the entry leaves its queue at the next clock edge.

Top module: `rank_cmd_sel`

## Requirements
- R1: After synchronous reset the block is in read direction, shows no grant and no hold, and both run counters are zero.
- R2: A grant only names an entry of the queue matching the current direction; `grant_write` is 0 for the read queue and 1 for the write queue, and `write_mode` equals 1 in write direction.
- R3: Only entries whose valid and ready bits are both set can be granted; without a rank preference, the ready entry with the lowest slot index (the oldest) is chosen.
- R4: When the previous burst went in the current direction, the lowest-indexed ready entry whose rank equals the previous burst's rank is chosen ahead of any older entry with another rank.
- R5: For the first burst after a change of direction (and the first burst after reset) no rank preference applies and the oldest ready entry is chosen.
- R6: A burst to a different rank than the previous burst is granted only after at least `T_CS` (default 2) cycles without a grant; same rank and same direction bursts may be granted on consecutive cycles.
- R7: A write following a read needs at least `T_RTW` (default 3) empty cycles and a read following a write needs at least `T_WTR` (default 4) empty cycles, each plus `T_CS` if the rank also changes.
- R8: In read direction, the block changes to write direction at the next clock edge when write occupancy is at least `HI_TH` (default 3), or when the read queue is empty and at least one write is queued; otherwise it stays in read direction.
- R9: In write direction, the block changes to read direction at the next clock edge when the write queue is empty, or when reads are queued and write occupancy is at most `LO_TH` (default 1); otherwise it stays in write direction.
- R10: `rd_run` counts read grants since the latest grant in the other direction (restarting at 1), `wr_run` does the same for writes; both saturate at all ones and keep their value while the other direction issues.
- R11: `hold` is 1 exactly when the current-direction queue has a grantable entry but the required empty-cycle gap has not yet elapsed; `hold` and `grant_valid` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | DEPTH | Read queue slot occupied, slot 0 oldest |
| rd_ready | input | DEPTH | Read queue slot passes bank timing |
| rd_rank | input | DEPTH*RANK_W | Target rank of each read slot, slot i at bits i*RANK_W |
| wr_valid | input | DEPTH | Write queue slot occupied, slot 0 oldest |
| wr_ready | input | DEPTH | Write queue slot passes bank timing |
| wr_rank | input | DEPTH*RANK_W | Target rank of each write slot, slot i at bits i*RANK_W |
| grant_valid | output | 1 | The named entry is issued this cycle |
| grant_write | output | 1 | 1 when the granted entry is from the write queue |
| grant_idx | output | IDX_W | Slot index of the granted entry |
| grant_rank | output | RANK_W | Rank of the granted entry |
| hold | output | 1 | A candidate exists but the bus gap is still running |
| write_mode | output | 1 | Current bus direction, 1 for write |
| rd_run | output | CNT_W | Reads issued in the current or latest read run |
| wr_run | output | CNT_W | Writes issued in the current or latest write run |

## Verification
Directed sequences first put an older entry of a foreign rank ahead of a same-rank entry, which separates the rank preference from plain oldest-first choice, and then fill the write queue to the high threshold, which shows the direction change, the lost preference on the first burst after it and the read-to-write gap. Constrained random phases then vary arrival rates so that the write queue sits below, between and above the two thresholds, which tells hysteresis apart from a single-threshold switch, while random ranks and ready flags exercise every gap combination (same rank, rank change, turnaround, both) and unready older entries being skipped.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    // number of set bits in a mask of up to 64 slots
    function automatic int unsigned bits_set(input logic [63:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            n += int'(v[i]);
        end
        return n;
    endfunction

    // empty cycles the bus must see before a burst of the given kind
    function automatic int unsigned spacing_need(
        input logic        have_prev,
        input dir_e        prev_dir,
        input dir_e        next_dir,
        input logic        same_rank,
        input int unsigned t_cs,
        input int unsigned t_rtw,
        input int unsigned t_wtr
    );
        int unsigned n;
        n = 0;
        if (have_prev) begin
            if (prev_dir != next_dir) begin
                n = (prev_dir == DIR_RD) ? t_rtw : t_wtr;
            end
            if (!same_rank) begin
                n += t_cs;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/rcs_pick.sv
module rcs_pick
    import rcs_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int RANK_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic [DEPTH-1:0]        valid,
    input  logic [DEPTH-1:0]        ready,
    input  logic [DEPTH*RANK_W-1:0] ranks,
    input  logic                    pref_en,
    input  logic [RANK_W-1:0]       pref_rank,
    output logic                    found,
    output logic [IDX_W-1:0]        idx,
    output logic [RANK_W-1:0]       sel_rank
);

    logic             any_hit;
    logic             pref_hit;
    logic [IDX_W-1:0] any_idx;
    logic [IDX_W-1:0] pref_idx;

    // scan from youngest to oldest so the lowest index wins
    always_comb begin
        any_hit  = 1'b0;
        pref_hit = 1'b0;
        any_idx  = '0;
        pref_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (valid[i] && ready[i]) begin
                any_hit = 1'b1;
                any_idx = IDX_W'(i);
                if (pref_en && (ranks[i*RANK_W +: RANK_W] == pref_rank)) begin
                    pref_hit = 1'b1;
                    pref_idx = IDX_W'(i);
                end
            end
        end
    end

    assign found    = any_hit;
    assign idx      = pref_hit ? pref_idx : any_idx;
    assign sel_rank = ranks[idx*RANK_W +: RANK_W];

endmodule

// File: rtl/rcs_mode.sv
module rcs_mode
    import rcs_pkg::*;
#(
    parameter int OCC_W = 3,
    parameter int HI_TH = 3,
    parameter int LO_TH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] rd_occ,
    input  logic [OCC_W-1:0] wr_occ,
    output dir_e             dir
);

    dir_e dir_q;
    dir_e dir_d;
    logic wr_at_hi;
    logic wr_at_lo;
    logic rd_empty;
    logic wr_empty;

    assign wr_at_hi = (32'(wr_occ) >= 32'(HI_TH));
    assign wr_at_lo = (32'(wr_occ) <= 32'(LO_TH));
    assign rd_empty = (rd_occ == '0);
    assign wr_empty = (wr_occ == '0);

    always_comb begin
        dir_d = dir_q;
        if (dir_q == DIR_RD) begin
            if (wr_at_hi || (rd_empty && !wr_empty)) begin
                dir_d = DIR_WR;
            end
        end else begin
            if (wr_empty || (!rd_empty && wr_at_lo)) begin
                dir_d = DIR_RD;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_RD;
        end else begin
            dir_q <= dir_d;
        end
    end

    assign dir = dir_q;

    // R8: a full-enough write queue moves the bus to writes
    p_enter_wr_r8: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_RD && 32'(wr_occ) >= 32'(HI_TH)) |=> (dir == DIR_WR));

    // R8: no writes queued keeps the bus on reads
    p_rd_stays_r8: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_RD && wr_occ == '0) |=> (dir == DIR_RD));

    // R9: above the low threshold the write run continues
    p_wr_stays_r9: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_WR && 32'(wr_occ) > 32'(LO_TH)) |=> (dir == DIR_WR));

    // R9: an empty write queue always ends write direction
    p_wr_leaves_r9: assert property (@(posedge clk) disable iff (rst)
        (dir == DIR_WR && wr_occ == '0) |=> (dir == DIR_RD));

endmodule

// File: rtl/rcs_track.sv
module rcs_track
    import rcs_pkg::*;
#(
    parameter int RANK_W = 2,
    parameter int CNT_W  = 8,
    parameter int T_CS   = 2,
    parameter int T_RTW  = 3,
    parameter int T_WTR  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  dir_e              cur_dir,
    input  logic [RANK_W-1:0] cand_rank,
    output logic              spacing_ok,
    output logic              have_prev,
    output dir_e              prev_dir,
    output logic [RANK_W-1:0] prev_rank,
    output logic [CNT_W-1:0]  rd_run,
    output logic [CNT_W-1:0]  wr_run
);

    localparam int TURN_MAX = (T_RTW > T_WTR) ? T_RTW : T_WTR;
    localparam int IDLE_W   = $clog2(T_CS + TURN_MAX + 2);
    localparam logic [IDLE_W-1:0] IDLE_MAX = '1;
    localparam logic [CNT_W-1:0]  RUN_MAX  = '1;

    logic [IDLE_W-1:0] idle_q;
    logic              have_q;
    dir_e              pdir_q;
    logic [RANK_W-1:0] prank_q;
    logic [CNT_W-1:0]  rd_run_q;
    logic [CNT_W-1:0]  wr_run_q;
    int unsigned       need;

    always_comb begin
        need = spacing_need(have_q, pdir_q, cur_dir, (prank_q == cand_rank),
                            unsigned'(T_CS), unsigned'(T_RTW), unsigned'(T_WTR));
    end

    assign spacing_ok = (32'(idle_q) >= need);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q   <= '0;
            have_q   <= 1'b0;
            pdir_q   <= DIR_RD;
            prank_q  <= '0;
            rd_run_q <= '0;
            wr_run_q <= '0;
        end else if (issue) begin
            idle_q  <= '0;
            have_q  <= 1'b1;
            pdir_q  <= cur_dir;
            prank_q <= cand_rank;
            if (cur_dir == DIR_RD) begin
                if (have_q && pdir_q == DIR_RD) begin
                    rd_run_q <= (rd_run_q == RUN_MAX) ? rd_run_q : rd_run_q + 1'b1;
                end else begin
                    rd_run_q <= CNT_W'(1);
                end
            end else begin
                if (have_q && pdir_q == DIR_WR) begin
                    wr_run_q <= (wr_run_q == RUN_MAX) ? wr_run_q : wr_run_q + 1'b1;
                end else begin
                    wr_run_q <= CNT_W'(1);
                end
            end
        end else begin
            idle_q <= (idle_q == IDLE_MAX) ? idle_q : idle_q + 1'b1;
        end
    end

    assign have_prev = have_q;
    assign prev_dir  = pdir_q;
    assign prev_rank = prank_q;
    assign rd_run    = rd_run_q;
    assign wr_run    = wr_run_q;

    // R10: a read following a read extends the read run
    p_run_inc_r10: assert property (@(posedge clk) disable iff (rst)
        (issue && have_q && pdir_q == DIR_RD && cur_dir == DIR_RD && rd_run_q != RUN_MAX)
        |=> (rd_run_q == $past(rd_run_q) + 1'b1));

    // R10: the first write after reads restarts the write run
    p_run_start_r10: assert property (@(posedge clk) disable iff (rst)
        (issue && cur_dir == DIR_WR && (!have_q || pdir_q == DIR_RD))
        |=> (wr_run_q == CNT_W'(1)));

    // R10: reads leave the write run untouched
    p_run_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (issue && cur_dir == DIR_RD) |=> $stable(wr_run_q));

endmodule

// File: rtl/rank_cmd_sel.sv
module rank_cmd_sel
    import rcs_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int RANK_W = 2,
    parameter int T_CS   = 2,
    parameter int T_RTW  = 3,
    parameter int T_WTR  = 4,
    parameter int HI_TH  = 3,
    parameter int LO_TH  = 1,
    parameter int CNT_W  = 8,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DEPTH-1:0]        rd_valid,
    input  logic [DEPTH-1:0]        rd_ready,
    input  logic [DEPTH*RANK_W-1:0] rd_rank,
    input  logic [DEPTH-1:0]        wr_valid,
    input  logic [DEPTH-1:0]        wr_ready,
    input  logic [DEPTH*RANK_W-1:0] wr_rank,
    output logic                    grant_valid,
    output logic                    grant_write,
    output logic [IDX_W-1:0]        grant_idx,
    output logic [RANK_W-1:0]       grant_rank,
    output logic                    hold,
    output logic                    write_mode,
    output logic [CNT_W-1:0]        rd_run,
    output logic [CNT_W-1:0]        wr_run
);

    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam int NQ    = 2;

    logic [DEPTH-1:0]        q_valid [NQ];
    logic [DEPTH-1:0]        q_ready [NQ];
    logic [DEPTH*RANK_W-1:0] q_rank  [NQ];
    logic                    p_found [NQ];
    logic [IDX_W-1:0]        p_idx   [NQ];
    logic [RANK_W-1:0]       p_rank  [NQ];

    logic [OCC_W-1:0]  rd_occ;
    logic [OCC_W-1:0]  wr_occ;
    dir_e              cur_dir;
    logic              cur_q;
    logic              cand_found;
    logic [RANK_W-1:0] cand_rank;
    logic              spacing_ok;
    logic              have_prev;
    dir_e              prev_dir;
    logic [RANK_W-1:0] prev_rank;

    assign q_valid[0] = rd_valid;
    assign q_valid[1] = wr_valid;
    assign q_ready[0] = rd_ready;
    assign q_ready[1] = wr_ready;
    assign q_rank[0]  = rd_rank;
    assign q_rank[1]  = wr_rank;

    assign rd_occ = OCC_W'(bits_set(64'(rd_valid)));
    assign wr_occ = OCC_W'(bits_set(64'(wr_valid)));

    // one picker per queue; queue 0 serves reads, queue 1 serves writes
    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic q_pref;
        assign q_pref = have_prev && (prev_dir == dir_e'(1'(q)));
        rcs_pick #(
            .DEPTH (DEPTH),
            .RANK_W(RANK_W),
            .IDX_W (IDX_W)
        ) u_pick (
            .valid    (q_valid[q]),
            .ready    (q_ready[q]),
            .ranks    (q_rank[q]),
            .pref_en  (q_pref),
            .pref_rank(prev_rank),
            .found    (p_found[q]),
            .idx      (p_idx[q]),
            .sel_rank (p_rank[q])
        );
    end

    rcs_mode #(
        .OCC_W(OCC_W),
        .HI_TH(HI_TH),
        .LO_TH(LO_TH)
    ) u_mode (
        .clk   (clk),
        .rst   (rst),
        .rd_occ(rd_occ),
        .wr_occ(wr_occ),
        .dir   (cur_dir)
    );

    assign cur_q      = (cur_dir == DIR_WR);
    assign cand_found = p_found[cur_q];
    assign cand_rank  = p_rank[cur_q];

    rcs_track #(
        .RANK_W(RANK_W),
        .CNT_W (CNT_W),
        .T_CS  (T_CS),
        .T_RTW (T_RTW),
        .T_WTR (T_WTR)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .issue     (grant_valid),
        .cur_dir   (cur_dir),
        .cand_rank (cand_rank),
        .spacing_ok(spacing_ok),
        .have_prev (have_prev),
        .prev_dir  (prev_dir),
        .prev_rank (prev_rank),
        .rd_run    (rd_run),
        .wr_run    (wr_run)
    );

    assign grant_valid = cand_found && spacing_ok;
    assign hold        = cand_found && !spacing_ok;
    assign grant_write = cur_q;
    assign grant_idx   = p_idx[cur_q];
    assign grant_rank  = cand_rank;
    assign write_mode  = cur_q;

    // R3: only occupied, bank-ready slots are granted
    p_grant_entry_r3: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> (q_valid[cur_q][grant_idx] && q_ready[cur_q][grant_idx]));

    // R6: a rank change never follows a grant on the next cycle
    if (T_CS > 0) begin : g_rank_gap
        p_rank_gap_r6: assert property (@(posedge clk) disable iff (rst)
            grant_valid |=> !(grant_valid && grant_rank != $past(grant_rank)));
    end

    // R7: a direction change never follows a grant on the next cycle
    if (T_RTW > 0 && T_WTR > 0) begin : g_turn_gap
        p_turn_gap_r7: assert property (@(posedge clk) disable iff (rst)
            grant_valid |=> !(grant_valid && grant_write != $past(grant_write)));
    end

    // R11: hold and grant are exclusive and hold needs a candidate slot
    p_hold_cand_r11: assert property (@(posedge clk) disable iff (rst)
        hold |-> (!grant_valid && (q_valid[cur_q] & q_ready[cur_q]) != '0));

endmodule

// File: tb/rank_cmd_sel_test.sv
module rank_cmd_sel_test;

    localparam int DEPTH = 4;
    localparam int RW    = 2;
    localparam int TCS   = 2;
    localparam int TRTW  = 3;
    localparam int TWTR  = 4;
    localparam int HI    = 3;
    localparam int LO    = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DEPTH-1:0]    rd_valid, rd_ready, wr_valid, wr_ready;
    logic [DEPTH*RW-1:0] rd_rank, wr_rank;
    logic                grant_valid, grant_write, hold, write_mode;
    logic [1:0]          grant_idx;
    logic [RW-1:0]       grant_rank;
    logic [7:0]          rd_run, wr_run;

    rank_cmd_sel uut (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_rank(rd_rank),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_rank(wr_rank),
        .grant_valid(grant_valid), .grant_write(grant_write),
        .grant_idx(grant_idx), .grant_rank(grant_rank), .hold(hold),
        .write_mode(write_mode), .rd_run(rd_run), .wr_run(wr_run)
    );

    always #10 clk = ~clk;   // 50 MHz

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench-side queues, slot 0 oldest, contiguous
    int qcnt [2];
    int qrank[2][DEPTH];
    bit qrdy [2][DEPTH];

    // bench model state
    int e_mode, e_have, e_pdir, e_prank, e_idle, e_rrun, e_wrun;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int gap_for(input int ndir, input int nrank);
        int g;
        g = 0;
        if (e_have != 0) begin
            if (e_pdir != ndir) g = (e_pdir == 0) ? TRTW : TWTR;
            if (e_prank != nrank) g += TCS;
        end
        return g;
    endfunction

    task automatic push(input int q, input int rk, input bit rdy);
        if (qcnt[q] < DEPTH) begin
            qrank[q][qcnt[q]] = rk;
            qrdy[q][qcnt[q]]  = rdy;
            qcnt[q]++;
        end
    endtask

    task automatic drive();
        for (int i = 0; i < DEPTH; i++) begin
            rd_valid[i] = (i < qcnt[0]);
            rd_ready[i] = (i < qcnt[0]) ? qrdy[0][i] : 1'b0;
            rd_rank[i*RW +: RW] = (i < qcnt[0]) ? RW'(qrank[0][i]) : '0;
            wr_valid[i] = (i < qcnt[1]);
            wr_ready[i] = (i < qcnt[1]) ? qrdy[1][i] : 1'b0;
            wr_rank[i*RW +: RW] = (i < qcnt[1]) ? RW'(qrank[1][i]) : '0;
        end
    endtask

    // one cycle: drive at negedge, check mid-low phase, update model at posedge
    task automatic step();
        int q, sel, pref, nr;
        bit eg, eh;
        string gtag;
        drive();
        #5;
        q = e_mode;
        sel = -1;
        pref = 0;
        if (e_have != 0 && e_pdir == q) begin
            for (int i = DEPTH - 1; i >= 0; i--)
                if (i < qcnt[q] && qrdy[q][i] && qrank[q][i] == e_prank) sel = i;
            if (sel >= 0) pref = 1;
        end
        if (sel < 0) begin
            for (int i = DEPTH - 1; i >= 0; i--)
                if (i < qcnt[q] && qrdy[q][i]) sel = i;
        end
        eg = (sel >= 0) && (e_idle >= gap_for(q, (sel >= 0) ? qrank[q][sel] : 0));
        eh = (sel >= 0) && !eg;
        if (sel >= 0 && e_have != 0 && e_pdir != q) gtag = "R7";
        else gtag = "R6";
        chk(grant_valid == eg, gtag, grant_valid, eg);
        chk(hold == eh, "R11", hold, eh);
        chk(int'(write_mode) == q, (q == 1) ? "R9" : "R8", write_mode, q);
        chk(int'(rd_run) == e_rrun, "R10", rd_run, e_rrun);
        chk(int'(wr_run) == e_wrun, "R10", wr_run, e_wrun);
        if (eg && grant_valid) begin
            chk(int'(grant_write) == q, "R2", grant_write, q);
            if (pref != 0)
                chk(int'(grant_idx) == sel, "R4", grant_idx, sel);
            else if (e_have != 0 && e_pdir != q)
                chk(int'(grant_idx) == sel, "R5", grant_idx, sel);
            else
                chk(int'(grant_idx) == sel, "R3", grant_idx, sel);
            chk(int'(grant_rank) == qrank[q][sel], "R3", grant_rank, qrank[q][sel]);
        end
        // next direction from occupancy seen this cycle
        if (e_mode == 0) begin
            if (qcnt[1] >= HI || (qcnt[0] == 0 && qcnt[1] > 0)) e_mode = 1;
        end else begin
            if (qcnt[1] == 0 || (qcnt[0] > 0 && qcnt[1] <= LO)) e_mode = 0;
        end
        if (eg) begin
            nr = qrank[q][sel];
            if (q == 0) e_rrun = (e_have != 0 && e_pdir == 0) ? ((e_rrun < 255) ? e_rrun + 1 : 255) : 1;
            else        e_wrun = (e_have != 0 && e_pdir == 1) ? ((e_wrun < 255) ? e_wrun + 1 : 255) : 1;
            e_have = 1; e_pdir = q; e_prank = nr; e_idle = 0;
            for (int i = sel; i < DEPTH - 1; i++) begin
                qrank[q][i] = qrank[q][i+1];
                qrdy[q][i]  = qrdy[q][i+1];
            end
            qcnt[q]--;
        end else begin
            e_idle = (e_idle < 1000) ? e_idle + 1 : 1000;
        end
        @(negedge clk);
    endtask

    task automatic reroll_ready(input int pct);
        for (int q = 0; q < 2; q++)
            for (int i = 0; i < DEPTH; i++)
                qrdy[q][i] = (($urandom % 100) < pct);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        qcnt[0] = 0; qcnt[1] = 0;
        e_mode = 0; e_have = 0; e_pdir = 0; e_prank = 0; e_idle = 0; e_rrun = 0; e_wrun = 0;
        drive();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #5;
        // R1: reset state
        chk(grant_valid == 1'b0, "R1", grant_valid, 0);
        chk(hold == 1'b0, "R1", hold, 0);
        chk(write_mode == 1'b0, "R1", write_mode, 0);
        chk(rd_run == 8'd0 && wr_run == 8'd0, "R1", rd_run, 0);
        @(negedge clk);

        // R4: older foreign-rank read sits ahead of a same-rank read
        push(0, 2, 1'b1);
        step();                       // grants rank 2 (first burst, R5 oldest)
        push(0, 1, 1'b1);
        push(0, 2, 1'b1);
        step();                       // prefers slot 1 (rank 2)
        step();                       // rank 1 needs the T_CS gap: hold
        repeat (3) step();

        // R8/R5/R7: fill writes to the high threshold while reads wait
        push(0, 3, 1'b1);
        push(1, 0, 1'b1); push(1, 3, 1'b1); push(1, 3, 1'b1);
        repeat (12) step();

        // R9: hysteresis with writes between the thresholds
        push(1, 1, 1'b1); push(1, 1, 1'b1);
        push(0, 0, 1'b1);
        repeat (10) step();
        repeat (10) step();

        // constrained random phases with shifting arrival rates
        for (int ph = 0; ph < 12; ph++) begin
            int prd, pwr;
            prd = 20 + (ph % 4) * 20;
            pwr = 10 + ((ph * 3) % 5) * 15;
            for (int c = 0; c < 300; c++) begin
                reroll_ready(80);
                if (($urandom % 100) < prd) push(0, int'($urandom % 4), 1'b1);
                if (($urandom % 100) < pwr) push(1, int'($urandom % 4), 1'b1);
                if ((ph % 3) == 2) begin
                    // rank-sticky traffic favours the same-rank path
                    for (int i = 0; i < qcnt[0]; i++) if (($urandom % 2) == 0) qrank[0][i] = 1;
                end
                step();
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule